// File: doc/BRIEF.md
# RDS Block Synchronizer and Checker

This block takes a serial stream of already recovered radio data bits, each marked by a one-cycle valid strobe. It groups the bits into 26-bit blocks, each made of a 16-bit information word followed by a 10-bit checkword. It finds the block and group boundaries by itself. For every 26-bit window it computes a syndrome: the received checkword XOR the cyclic remainder of the information word. It then compares that syndrome with the five standard offset words.

Once aligned, it reports every block at its boundary. The information word and the raw checkword are latched, together with a validity flag and the position of the block in its group (0 to 3), and a one-cycle interrupt pulse is raised. Errors are only detected and never corrected. An enable input gates the whole block. A hold input keeps the present alignment locked whatever errors arrive.

Top module: `rds_block_sync`

## Requirements
- R1: On a report, `data_o` holds the first 16 received bits of the block and `status_o[12:3]` holds the last 10 received bits. The earliest received bit lands in the most significant position.
- R2: `irq_o` rises in the cycle after the clock edge that samples the 26th bit of a reported block, and it is high for exactly one cycle.
- R3: `status_o` packs three fields: the checkword in bits 12:3, the validity flag in bit 2 (1 = syndrome matched the expected offset), and the block index in bits 1:0.
- R4: The remainder uses the generator x^10+x^8+x^7+x^5+x^4+x^3+1. The offsets map to block indices as follows: 0x0FC gives index 0, 0x198 gives index 1, 0x168 and 0x350 both give index 2, and 0x1B4 gives index 3.
- R5: While searching, any bit position whose syndrome matches an offset starts a trial. Sync is declared only when the block 26 bits later matches the next offset in group order. The first block is not reported, and the confirming block is the first one reported.
- R6: After reset, `data_o`, `status_o` and `irq_o` are 0. Between reports, `data_o` and `status_o` keep their values.
- R7: While `enable_i` is 0, strobed bits are ignored, no interrupt is raised, and the alignment is kept, so the stream resumes where it stopped.
- R8: While `hold_sync_i` is 1 and the block is in sync, it stays in sync and keeps the index sequence whatever errors arrive. Bad blocks are still reported as invalid.
- R9: A block whose syndrome does not match the expected offset is reported with validity 0. Its information word and checkword are passed through exactly as received, and the index sequence advances.
- R10: With `hold_sync_i` at 0, sync is dropped after reporting any block that leaves 8 or more invalid blocks among the last 16 reported. After that no report is made until a new search is confirmed under R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered data bit |
| bit_valid_i | input | 1 | One-cycle strobe marking `bit_i` as a new bit |
| enable_i | input | 1 | Block enable |
| hold_sync_i | input | 1 | Keep the current alignment regardless of errors |
| data_o | output | 16 | Information word of the last reported block |
| status_o | output | 13 | Checkword, validity and block index of the last reported block |
| irq_o | output | 1 | One-cycle pulse per reported block |

## Verification
A wrong alignment or a wrong expected-index counter shows up at the very next report, 26 strobed bits later. The index field steps out of sequence, or the validity flag drops while the stream itself is clean. A wrong search or drop decision shows up as an interrupt that is missing or extra within one block time. A history that counts wrongly shows up as a drop that comes one report too early or too late, in a sequence whose error count is known. A data path fault shows up at once as a mismatch between the latched words and the bits that were sent.

// File: rtl/rds_sync_pkg.sv
package rds_sync_pkg;
  localparam int DATA_W  = 16;
  localparam int CHK_W   = 10;
  localparam int BLK_W   = DATA_W + CHK_W;
  localparam int NUM_OFF = 5;
  localparam int IDX_W   = 2;
  localparam int STAT_W  = CHK_W + 1 + IDX_W;

  // generator without its x^10 term
  localparam logic [CHK_W-1:0] GEN_LO = 10'h1B9;
  localparam logic [CHK_W-1:0] OFFSET [NUM_OFF] =
    '{10'h0FC, 10'h198, 10'h168, 10'h350, 10'h1B4};
  localparam logic [IDX_W-1:0] OFF_IDX [NUM_OFF] =
    '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3};

  typedef enum logic [1:0] {ST_SEARCH, ST_CONFIRM, ST_LOCKED} sync_st_e;

  // remainder of d * x^10 modulo the generator
  function automatic logic [CHK_W-1:0] rds_rem(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = d[i] ^ r[CHK_W-1];
      r  = {r[CHK_W-2:0], 1'b0};
      if (fb) r = r ^ GEN_LO;
    end
    return r;
  endfunction
endpackage

// File: rtl/rds_syndrome.sv
module rds_syndrome
  import rds_sync_pkg::*;
(
  input  logic [BLK_W-1:0]   win_i,
  output logic [CHK_W-1:0]   syn_o,
  output logic [NUM_OFF-1:0] match_o
);
  assign syn_o = win_i[CHK_W-1:0] ^ rds_rem(win_i[BLK_W-1:CHK_W]);

  for (genvar k = 0; k < NUM_OFF; k++) begin : g_match
    assign match_o[k] = (syn_o == OFFSET[k]);
  end
endmodule

// File: rtl/rds_sync_ctrl.sv
module rds_sync_ctrl
  import rds_sync_pkg::*;
#(
  parameter int HIST_W   = 16,
  parameter int DROP_THR = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               hold_i,
  input  logic [NUM_OFF-1:0] match_i,
  output logic               emit_o,
  output logic               emit_valid_o,
  output logic [IDX_W-1:0]   emit_idx_o
);
  localparam int CNT_W = $clog2(BLK_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_W - 1);

  sync_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, fill_q, fill_d;
  logic [IDX_W-1:0]  exp_q, exp_d;
  logic [HIST_W-1:0] hist_q, hist_d;
  logic              full, idx_ok, found;
  logic [IDX_W-1:0]  found_idx;

  assign full = (fill_q >= LAST);

  always_comb begin
    idx_ok    = 1'b0;
    found     = 1'b0;
    found_idx = '0;
    for (int k = NUM_OFF - 1; k >= 0; k--) begin
      if (match_i[k] && OFF_IDX[k] == exp_q) idx_ok = 1'b1;
      if (match_i[k]) begin
        found     = 1'b1;
        found_idx = OFF_IDX[k];
      end
    end
  end

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    exp_d        = exp_q;
    hist_d       = hist_q;
    fill_d       = fill_q;
    emit_o       = 1'b0;
    emit_valid_o = 1'b0;
    emit_idx_o   = exp_q;
    if (step_i) begin
      if (!full) fill_d = fill_q + 1'b1;
      cnt_d = cnt_q + 1'b1;
      unique case (st_q)
        ST_SEARCH: begin
          if (full && found) begin
            st_d  = ST_CONFIRM;
            cnt_d = '0;
            exp_d = found_idx + 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            if (idx_ok) begin
              st_d         = ST_LOCKED;
              emit_o       = 1'b1;
              emit_valid_o = 1'b1;
              exp_d        = exp_q + 1'b1;
              hist_d       = '0;
            end else begin
              st_d = ST_SEARCH;
            end
          end
        end
        ST_LOCKED: begin
          if (cnt_q == LAST) begin
            cnt_d        = '0;
            emit_o       = 1'b1;
            emit_valid_o = idx_ok;
            exp_d        = exp_q + 1'b1;
            hist_d       = {hist_q[HIST_W-2:0], ~idx_ok};
            if (!hold_i && $countones(hist_d) >= DROP_THR) st_d = ST_SEARCH;
          end
        end
        default: st_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEARCH;
      cnt_q  <= '0;
      fill_q <= '0;
      exp_q  <= '0;
      hist_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fill_q <= fill_d;
      exp_q  <= exp_d;
      hist_q <= hist_d;
    end
  end

  // R2
  emit_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |=> !emit_o);
  // R5
  no_direct_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH) |=> (st_q != ST_LOCKED));
  // R8
  hold_keeps_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && st_q == ST_LOCKED) |=> (st_q == ST_LOCKED));
  // R9
  emit_only_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |-> (st_q != ST_SEARCH));
endmodule

// File: rtl/rds_block_sync.sv
module rds_block_sync
  import rds_sync_pkg::*;
#(
  parameter int HIST_W   = 16,
  parameter int DROP_THR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              enable_i,
  input  logic              hold_sync_i,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic [BLK_W-1:0]   win_q, win_d;
  logic [CHK_W-1:0]   syn;
  logic [NUM_OFF-1:0] match;
  logic               step, emit, emit_valid;
  logic [IDX_W-1:0]   emit_idx;

  assign step  = enable_i & bit_valid_i;
  assign win_d = {win_q[BLK_W-2:0], bit_i};

  rds_syndrome u_syn (
    .win_i   (win_d),
    .syn_o   (syn),
    .match_o (match)
  );

  rds_sync_ctrl #(.HIST_W(HIST_W), .DROP_THR(DROP_THR)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .hold_i       (hold_sync_i),
    .match_i      (match),
    .emit_o       (emit),
    .emit_valid_o (emit_valid),
    .emit_idx_o   (emit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      data_o   <= '0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= emit;
      if (step) win_q <= win_d;
      if (emit) begin
        data_o   <= win_d[BLK_W-1:CHK_W];
        status_o <= {win_d[CHK_W-1:0], emit_valid, emit_idx};
      end
    end
  end

  // R2
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R7
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_o);
  // R6
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> ($stable(data_o) && $stable(status_o)));
  // R3
  valid_needs_syndrome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit && emit_valid) |-> (match != '0));
endmodule

// File: tb/rds_block_sync_test.sv
module rds_block_sync_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0, bit_valid_i = 1'b0, enable_i = 1'b0, hold_sync_i = 1'b0;
  logic [15:0] data_o;
  logic [12:0] status_o;
  logic        irq_o;
  int          total = 0, bad = 0;

  localparam logic [9:0] OFFS [5] = '{10'h0FC, 10'h198, 10'h168, 10'h350, 10'h1B4};
  localparam int OA = 0, OB = 1, OC = 2, OCP = 3, OD = 4;

  always #(CLK_PERIOD/2) clk = ~clk;

  rds_block_sync uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .enable_i(enable_i), .hold_sync_i(hold_sync_i),
    .data_o(data_o), .status_o(status_o), .irq_o(irq_o)
  );

  // long division of d * x^10 by 0x5B9
  function automatic logic [9:0] ref_rem(input logic [15:0] d);
    logic [25:0] v;
    v = {d, 10'd0};
    for (int b = 25; b >= 10; b--)
      if (v[b]) v = v ^ (26'h5B9 << (b - 10));
    return v[9:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_i = b;
    bit_valid_i = 1'b1;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  task automatic send_block(input logic [15:0] d, input int oid, input bit corrupt,
                            input bit exp_irq, input logic [1:0] exp_idx,
                            input bit exp_valid, input string req);
    logic [9:0]  c;
    logic [15:0] dd, prev_d, cap_d;
    logic [12:0] prev_s, cap_s;
    logic [25:0] w;
    int          n_irq, last_pos;
    c = ref_rem(d) ^ OFFS[oid];
    dd = corrupt ? (d ^ 16'h0001) : d;
    w = {dd, c};
    prev_d = data_o; prev_s = status_o;
    n_irq = 0; last_pos = -1; cap_d = '0; cap_s = '0;
    for (int i = 25; i >= 0; i--) begin
      send_bit(w[i]);
      if (irq_o) begin
        n_irq++;
        last_pos = i;
        cap_d = data_o;
        cap_s = status_o;
      end
    end
    check(n_irq == int'(exp_irq), req, "irq count", n_irq, exp_irq);
    if (exp_irq) begin
      // R2: pulse only after the last bit
      check(last_pos == 0, "R2", "irq bit position", last_pos, 0);
      // R1, R3
      check(cap_d == dd, "R1", "data word", cap_d, dd);
      check(cap_s == {c, exp_valid, exp_idx}, req, "status", cap_s, {c, exp_valid, exp_idx});
    end else begin
      // R6
      check(data_o == prev_d && status_o == prev_s, "R6", "regs held",
            {data_o, status_o}, {prev_d, prev_s});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    check(data_o == 0 && status_o == 0 && irq_o == 0, "R6", "reset",
          {data_o, status_o, irq_o}, 0);
    rst_ni = 1'b1;

    // R7: disabled, bits are ignored
    send_block(16'h1234, OA, 0, 0, 2'd0, 1, "R7");
    send_block(16'hABCD, OB, 0, 0, 2'd1, 1, "R7");

    enable_i = 1'b1;
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    // R5: first block is not reported; the second one confirms sync
    send_block(16'h1234, OA, 0, 0, 2'd0, 1, "R5");
    send_block(16'hABCD, OB, 0, 1, 2'd1, 1, "R5");
    send_block(16'h0F0F, OC, 0, 1, 2'd2, 1, "R4");
    send_block(16'hFFFF, OD, 0, 1, 2'd3, 1, "R4");
    send_block(16'h0000, OA, 0, 1, 2'd0, 1, "R3");
    send_block(16'h8001, OB, 0, 1, 2'd1, 1, "R1");
    // R4: C' is reported as index 2
    send_block(16'h5555, OCP, 0, 1, 2'd2, 1, "R4");
    send_block(16'hAAAA, OD, 0, 1, 2'd3, 1, "R4");
    // R9: error flagged, data passed raw
    send_block(16'h7E57, OA, 1, 1, 2'd0, 0, "R9");
    send_block(16'h1111, OB, 0, 1, 2'd1, 1, "R9");
    send_block(16'h2222, OC, 0, 1, 2'd2, 1, "R9");
    send_block(16'h3333, OD, 0, 1, 2'd3, 1, "R9");

    // R7: disabled mid-stream, alignment frozen
    enable_i = 1'b0;
    send_block(16'hDEAD, OB, 0, 0, 2'd1, 1, "R7");
    enable_i = 1'b1;
    send_block(16'h4444, OA, 0, 1, 2'd0, 1, "R7");

    // R8: hold keeps sync through ten bad blocks
    hold_sync_i = 1'b1;
    for (int n = 0; n < 10; n++) begin
      int oid;
      oid = ((n + 1) % 4 == 0) ? OA : ((n + 1) % 4 == 1) ? OB :
            ((n + 1) % 4 == 2) ? OC : OD;
      send_block(16'h0100 + 16'(n), oid, 1, 1, 2'((n + 1) % 4), 0, "R8");
    end
    send_block(16'h6666, OD, 0, 1, 2'd3, 1, "R8");

    // R10: release hold; errors in history force a drop after this report
    hold_sync_i = 1'b0;
    send_block(16'h7777, OA, 0, 1, 2'd0, 1, "R10");
    send_block(16'h8888, OB, 0, 0, 2'd1, 1, "R10");
    send_block(16'h9999, OC, 0, 1, 2'd2, 1, "R10");
    send_block(16'hCAFE, OD, 0, 1, 2'd3, 1, "R10");

    @(negedge clk);
    // R2: no lingering pulse
    check(irq_o == 0, "R2", "irq idle", irq_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule